// File: doc/BRIEF.md
# Power-of-Two Period Link Scheduler

This block paces eight logical transmit links against a common time base. A free-running timer splits time into base ticks of a fixed number of clock cycles (one millisecond in the target system). Link k has a period of 2^k ticks, so the whole pattern repeats every 128 ticks.

At each tick the block works out which links are due. It then triggers their packets one at a time. Every packet of the shortest-period link goes first, then every packet of the next link, and so on down to the 128-tick link. A per-link packet count says how many packets a link sends in one of its slots, and a per-link enable can take a link out of service. Each trigger names the link and the packet index within that slot. The frame generator answers with a one-cycle done pulse before the next trigger is issued. If a tick arrives before the previous tick's list is finished, the block drops the leftover work, flags an overrun and starts the new list.

Top module: `pow2_link_sched`

## Requirements
- R1: A base tick occurs every TICK_CYCLES clock cycles. The first tick after reset is numbered 1, and tick numbers repeat with a period of 128.
- R2: Link k (k = 0..7) is due in a tick whose number is a multiple of 2^k. Tick 128 (and every multiple of it) makes all eight links due.
- R3: Within one tick, every trigger for a lower-numbered link is issued before any trigger for a higher-numbered link.
- R4: A due link with packet count C gets exactly C triggers in that tick, with trig_idx running 0, 1, .., C-1 in ascending order.
- R5: trig is a single-cycle pulse. The first trigger of a tick appears two cycles after the tick. Each later trigger appears two cycles after the cycle in which gen_done was high.
- R6: A link whose link_en bit is 0, or whose 4-bit count field pkt_cnt[4k+3:4k] is zero, gets no trigger.
- R7: gen_done has no effect while no trigger is outstanding. In particular, it does not cause an extra trigger.
- R8: If a tick arrives while triggers from the previous tick are still outstanding or pending, overrun pulses for one cycle one cycle after that tick. The unfinished work is discarded, and the new tick's list starts two cycles after the tick. A gen_done in the tick cycle itself is discarded too.
- R9: While reset is held, trig, overrun, trig_link and trig_idx are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_en | input | N_LINKS | Per-link enable, bit k for link k |
| pkt_cnt | input | N_LINKS*CNT_W | Packets per slot; the field for link k sits at bits [CNT_W*k+CNT_W-1 : CNT_W*k] |
| gen_done | input | 1 | One-cycle pulse from the frame generator ending the current packet |
| trig | output | 1 | One-cycle pulse starting generation of one packet |
| trig_link | output | $clog2(N_LINKS) | Link of the current trigger, valid with trig |
| trig_idx | output | CNT_W | Packet index within the link's slot, valid with trig |
| overrun | output | 1 | One-cycle pulse when a tick cuts off unfinished work |

## Verification
Every result has a fixed latency. The first trigger of a tick is due two cycles after the tick, and each later trigger two cycles after the done cycle. An overrun pulse is due one cycle after the tick that ends unfinished work. The bench keeps a behavioural queue of the triggers each tick owes and records the absolute cycle at which the next trigger or overrun is due. On every cycle it compares trig and overrun against those cycle numbers, and it compares link and index against the head of the queue whenever a trigger appears. Configuration changes are applied only in tick cycles, so that the block and the model take the same snapshot.

// File: rtl/lsch_pkg.sv
package lsch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } lsch_state_e;

endpackage

// File: rtl/lsch_tick_timer.sv
module lsch_tick_timer #(
    parameter int TICK_CYCLES = 100000,
    parameter int NUM_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             tick,
    output logic [NUM_W-1:0] tick_num
);

    localparam int CYC_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic             tick;
        logic [NUM_W-1:0] num;
    } tmr_t;

    tmr_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.tick = 1'b0;
        r_d.cyc  = r_q.cyc + 1'b1;
        if (r_q.cyc == CYC_LAST) begin
            r_d.cyc  = '0;
            r_d.tick = 1'b1;
            r_d.num  = r_q.num + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tick     = r_q.tick;
    assign tick_num = r_q.num;

    // each new tick advances the tick number by exactly one (wrapping)
    assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick) |-> tick_num == NUM_W'($past(tick_num) + 1'b1));

endmodule

// File: rtl/lsch_due_mask.sv
module lsch_due_mask #(
    parameter int N_LINKS = 8,
    parameter int NUM_W   = N_LINKS - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_W-1:0]   tick_num,
    output logic [N_LINKS-1:0] due
);

    for (genvar k = 0; k < N_LINKS; k++) begin : g_due
        if (k == 0) begin : g_base
            assign due[k] = 1'b1;
        end else begin : g_div
            assign due[k] = (tick_num[k-1:0] == '0);
            // a link with a longer period is only due when all shorter ones are
            assert_due_nested_R2: assert property (@(posedge clk) disable iff (!rst_n)
                due[k] |-> due[k-1]);
        end
    end

endmodule

// File: rtl/lsch_server.sv
module lsch_server
    import lsch_pkg::*;
#(
    parameter int N_LINKS = 8,
    parameter int CNT_W   = 4,
    parameter int LID_W   = $clog2(N_LINKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [N_LINKS-1:0]         due,
    input  logic [N_LINKS-1:0]         link_en,
    input  logic [N_LINKS*CNT_W-1:0]   pkt_cnt,
    input  logic                       gen_done,
    output logic                       trig,
    output logic [LID_W-1:0]           trig_link,
    output logic [CNT_W-1:0]           trig_idx,
    output logic                       overrun
);

    typedef struct packed {
        lsch_state_e        st;
        logic [N_LINKS-1:0] pend;
        logic [CNT_W-1:0]   idx;
        logic               trig;
        logic [LID_W-1:0]   link;
        logic [CNT_W-1:0]   oidx;
        logic               ovr;
    } srv_t;

    srv_t r_q, r_d;

    logic [N_LINKS-1:0] elig;
    logic [LID_W-1:0]   sel;
    logic [CNT_W-1:0]   sel_cnt;
    logic               sel_last;

    always_comb begin
        for (int i = 0; i < N_LINKS; i++) begin
            elig[i] = due[i] & link_en[i] & (pkt_cnt[i*CNT_W +: CNT_W] != '0);
        end
    end

    // lowest pending link number wins: shortest period first
    always_comb begin
        sel = '0;
        for (int i = N_LINKS - 1; i >= 0; i--) begin
            if (r_q.pend[i]) begin
                sel = LID_W'(i);
            end
        end
    end

    assign sel_cnt  = pkt_cnt[sel*CNT_W +: CNT_W];
    assign sel_last = ({1'b0, r_q.idx} + 1'b1) >= {1'b0, sel_cnt};

    always_comb begin
        r_d      = r_q;
        r_d.trig = 1'b0;
        r_d.ovr  = 1'b0;
        if (tick) begin
            r_d.ovr  = (r_q.st != ST_IDLE);
            r_d.pend = elig;
            r_d.idx  = '0;
            r_d.st   = (elig != '0) ? ST_ISSUE : ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_ISSUE: begin
                    r_d.trig = 1'b1;
                    r_d.link = sel;
                    r_d.oidx = r_q.idx;
                    r_d.st   = ST_WAIT;
                end
                ST_WAIT: begin
                    if (gen_done) begin
                        if (sel_last) begin
                            r_d.pend[sel] = 1'b0;
                            r_d.idx       = '0;
                            r_d.st        = (r_d.pend != '0) ? ST_ISSUE : ST_IDLE;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                            r_d.st  = ST_ISSUE;
                        end
                    end
                end
                default: begin
                    r_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign trig      = r_q.trig;
    assign trig_link = r_q.link;
    assign trig_idx  = r_q.oidx;
    assign overrun   = r_q.ovr;

    assert_trig_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);

    assert_trig_after_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(r_q.st) == ST_ISSUE);

    assert_overrun_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(tick));

    assert_pend_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |-> (r_q.pend != '0));

endmodule

// File: rtl/pow2_link_sched.sv
module pow2_link_sched #(
    parameter int N_LINKS     = 8,
    parameter int CNT_W       = 4,
    parameter int TICK_CYCLES = 100000,
    localparam int LID_W      = $clog2(N_LINKS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_LINKS-1:0]       link_en,
    input  logic [N_LINKS*CNT_W-1:0] pkt_cnt,
    input  logic                     gen_done,
    output logic                     trig,
    output logic [LID_W-1:0]         trig_link,
    output logic [CNT_W-1:0]         trig_idx,
    output logic                     overrun
);

    localparam int NUM_W = N_LINKS - 1;

    logic               tick;
    logic [NUM_W-1:0]   tick_num;
    logic [N_LINKS-1:0] due;

    lsch_tick_timer #(
        .TICK_CYCLES (TICK_CYCLES),
        .NUM_W       (NUM_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .tick_num (tick_num)
    );

    lsch_due_mask #(
        .N_LINKS (N_LINKS),
        .NUM_W   (NUM_W)
    ) u_due (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_num (tick_num),
        .due      (due)
    );

    lsch_server #(
        .N_LINKS (N_LINKS),
        .CNT_W   (CNT_W),
        .LID_W   (LID_W)
    ) u_srv (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .due       (due),
        .link_en   (link_en),
        .pkt_cnt   (pkt_cnt),
        .gen_done  (gen_done),
        .trig      (trig),
        .trig_link (trig_link),
        .trig_idx  (trig_idx),
        .overrun   (overrun)
    );

endmodule

// File: tb/pow2_link_sched_tb_top.sv
module pow2_link_sched_tb_top;

    localparam int T  = 64;
    localparam int NL = 8;
    localparam int CW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   link_en = '0;
    logic [NL*CW-1:0] pkt_cnt = '0;
    logic            gen_done = 1'b0;
    logic            trig;
    logic [2:0]      trig_link;
    logic [CW-1:0]   trig_idx;
    logic            overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pow2_link_sched #(
        .N_LINKS     (NL),
        .CNT_W       (CW),
        .TICK_CYCLES (T)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_en   (link_en),
        .pkt_cnt   (pkt_cnt),
        .gen_done  (gen_done),
        .trig      (trig),
        .trig_link (trig_link),
        .trig_idx  (trig_idx),
        .overrun   (overrun)
    );

    int cfg_cnt[NL];
    bit [NL-1:0] cfg_en;
    int q_link[$];
    int q_idx[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply_cfg();
        link_en = cfg_en;
        for (int k = 0; k < NL; k++) pkt_cnt[k*CW +: CW] = cfg_cnt[k][CW-1:0];
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        int e;
        int tn;
        int dly;
        int exp_trig_at;
        int ov_at;
        int done_at;
        int phase;
        bit drv;
        bit stop;
        e = 0; dly = 1; exp_trig_at = -1; ov_at = -1; done_at = -1; phase = 1; stop = 0;
        // phase 1: every link enabled with one packet
        for (int k = 0; k < NL; k++) cfg_cnt[k] = 1;
        cfg_en = '1;
        apply_cfg();
        repeat (3) @(posedge clk);
        #2;
        // R9 reset values
        chk(trig == 1'b0, "R9 trig in reset", int'(trig), 0);
        chk(overrun == 1'b0, "R9 overrun in reset", int'(overrun), 0);
        chk(trig_link == 3'd0, "R9 trig_link in reset", int'(trig_link), 0);
        chk(trig_idx == '0, "R9 trig_idx in reset", int'(trig_idx), 0);
        rst_n = 1'b1;
        while (!stop) begin
            @(posedge clk);
            #2;
            e++;
            chk(trig == (e == exp_trig_at), "R1 R5 R7 trigger timing", int'(trig), int'(e == exp_trig_at));
            if (trig && e == exp_trig_at && q_link.size() > 0) begin
                chk(int'(trig_link) == q_link[0], "R2 R3 link order", int'(trig_link), q_link[0]);
                chk(int'(trig_idx) == q_idx[0], "R4 packet index", int'(trig_idx), q_idx[0]);
                chk(cfg_en[trig_link] && cfg_cnt[trig_link] > 0, "R6 link eligible", int'(trig_link), -1);
            end
            chk(overrun == (e == ov_at), "R8 overrun pulse", int'(overrun), int'(e == ov_at));
            if (trig) done_at = e + dly;
            drv = 1'b0;
            if (e % T == 0) begin
                tn = e / T;
                if (tn == 131) begin
                    phase = 2; dly = 2;
                    cfg_cnt = '{5, 4, 4, 3, 2, 0, 1, 1};
                    cfg_en = 8'b1011_1111;
                    apply_cfg();
                end else if (tn == 151) begin
                    phase = 3; dly = 9;
                    cfg_cnt = '{3, 2, 2, 1, 1, 1, 1, 1};
                    cfg_en = 8'b1111_1011;
                    apply_cfg();
                end else if (tn == 171) begin
                    stop = 1;
                end
                if (q_link.size() > 0) ov_at = e + 1;
                q_link.delete();
                q_idx.delete();
                for (int k = 0; k < NL; k++) begin
                    if (cfg_en[k] && cfg_cnt[k] > 0 && (tn % (1 << k)) == 0) begin
                        for (int i = 0; i < cfg_cnt[k]; i++) begin
                            q_link.push_back(k);
                            q_idx.push_back(i);
                        end
                    end
                end
                exp_trig_at = (q_link.size() > 0) ? e + 2 : -1;
                done_at = -1;
            end else if (e == done_at) begin
                drv = 1'b1;
                if (q_link.size() > 0) begin
                    void'(q_link.pop_front());
                    void'(q_idx.pop_front());
                end
                exp_trig_at = (q_link.size() > 0) ? e + 2 : -1;
                done_at = -1;
            end else if (phase == 1 && e % T == 40 && q_link.size() == 0) begin
                // R7: stray done while idle must not trigger anything
                drv = 1'b1;
            end
            gen_done = drv;
        end
        summary();
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule